// File: doc/BRIEF.md
# GF(4096) Composite-Field Multiplier

This block multiplies two 12-bit elements of GF(2^12). It treats the field as a quadratic extension of GF(2^6). Each operand splits into a high 6-bit half and a low 6-bit half. The halves are combined through GF(64) sub-multipliers built as unrolled shift-and-add networks, and the two result halves are packed back into one 12-bit word. Alongside the product, the block forms a generator-step value for the first operand. That value is the mapping used when log and antilog tables for a Reed-Solomon codec over this field are built.

A parameter selects how the output is timed. With a single output register the results appear one cycle after the inputs, together with a valid strobe. Without it, the multiplier is purely combinational.

Top module: `gf4k_tower_mul`

## Requirements
- R1: An operand splits with bits 11:6 as the high half and bits 5:0 as the low half. GF(64) multiplication is shift-and-add: after each doubling of the multiplicand, if bit 6 is set, 0x43 (x^6+x+1) is XORed in.
- R2: The high half of the product, bits 11:6, equals m(ah^al, bh^bl) ^ m(al, bl), where m is GF(64) multiplication.
- R3: The low half of the product, bits 5:0, equals m(m(ah, bh), 0x21) ^ m(al, bl). For example, 0x040 times 0x040 gives 0x061.
- R4: The product word is the high half shifted left by 6, XORed with the low half. For example, 0x002 times 0x003 gives 0x006.
- R5: If either operand is zero, the product is zero.
- R6: 0x001 is the identity, so 0x001 times b gives b.
- R7: Multiplication is commutative: a*b equals b*a for all operands.
- R8: The generator-step output is 0x001 when operand a is 0.
- R9: For nonzero a, the generator-step output is a multiplied by 0xE01.
- R10: With the output register enabled (the default), prod_o and step_o show the results for the inputs presented in the cycle valid_i was high. valid_o is high exactly one cycle after valid_i.
- R11: With the output register enabled, prod_o and step_o hold their values in any cycle after valid_i was low.
- R12: During and after reset, valid_o, prod_o and step_o are 0 until the first valid input is captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operands valid this cycle |
| a_i | input | 12 | First operand; also the generator-step input |
| b_i | input | 12 | Second operand |
| valid_o | output | 1 | Results valid |
| prod_o | output | 12 | a_i times b_i in GF(4096) |
| step_o | output | 12 | Generator-step value for a_i |

## Verification
Every value of operand a is paired with several operands b: zero, which shows the product is absorbed; one, which shows identity; a itself, which exercises the squaring path where both halves interact; the constant 0xE01; and two pseudo-random words that mix the halves. Each random pair is also applied in swapped order to compare the two products. Each value of a also checks the generator-step output, so the zero special case is separated from the scaled path. Two small hand-worked products pin the packing and the extension constant, and cycles with valid_i low show that the outputs hold.

// File: rtl/gf4k_pkg.sv
package gf4k_pkg;
  localparam int unsigned SUB_W          = 6;
  localparam logic [6:0]  SUB_POLY       = 7'h43;   // x^6 + x + 1
  localparam logic [5:0]  EXT_CONST      = 6'h21;
  localparam logic [11:0] GEN_STEP_CONST = 12'hE01;
endpackage

// File: rtl/gf_sub_mul.sv
// GF(2^W) shift-and-add multiplier, fully unrolled.
module gf_sub_mul #(
  parameter int unsigned W    = 6,
  parameter logic [W:0]  POLY = 7'h43
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] p_o
);
  logic [W-1:0] acc [W+1];
  logic [W-1:0] sh  [W];

  assign acc[0] = '0;
  assign sh[0]  = b_i;

  for (genvar i = 0; i < W; i++) begin : g_stage
    assign acc[i+1] = acc[i] ^ (a_i[i] ? sh[i] : '0);
    if (i < W - 1) begin : g_dbl
      logic [W:0] dbl;
      assign dbl     = {sh[i], 1'b0};
      assign sh[i+1] = dbl[W] ? (dbl[W-1:0] ^ POLY[W-1:0]) : dbl[W-1:0];
    end
  end

  assign p_o = acc[W];
endmodule

// File: rtl/gf_tower_mul.sv
// Degree-2 extension multiply over GF(2^HALF_W).
module gf_tower_mul #(
  parameter int unsigned     HALF_W = 6,
  parameter logic [HALF_W:0] POLY   = 7'h43,
  parameter logic [HALF_W-1:0] EXT  = 6'h21,
  localparam int unsigned    W      = 2 * HALF_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] p_o
);
  logic [HALF_W-1:0] ah, al, bh, bl;
  logic [HALF_W-1:0] m_sum, m_lo, m_hi, m_ext;

  assign {ah, al} = a_i;
  assign {bh, bl} = b_i;

  gf_sub_mul #(.W(HALF_W), .POLY(POLY)) u_m_sum (.a_i(ah ^ al), .b_i(bh ^ bl), .p_o(m_sum));
  gf_sub_mul #(.W(HALF_W), .POLY(POLY)) u_m_lo  (.a_i(al),      .b_i(bl),      .p_o(m_lo));
  gf_sub_mul #(.W(HALF_W), .POLY(POLY)) u_m_hi  (.a_i(ah),      .b_i(bh),      .p_o(m_hi));
  gf_sub_mul #(.W(HALF_W), .POLY(POLY)) u_m_ext (.a_i(m_hi),    .b_i(EXT),     .p_o(m_ext));

  assign p_o = {m_sum ^ m_lo, m_ext ^ m_lo};
endmodule

// File: rtl/gf4k_tower_mul.sv
module gf4k_tower_mul
  import gf4k_pkg::*;
#(
  parameter int unsigned       HALF_W  = SUB_W,
  parameter logic [HALF_W:0]   POLY    = SUB_POLY,
  parameter logic [HALF_W-1:0] EXT     = EXT_CONST,
  parameter logic [2*HALF_W-1:0] GEN   = GEN_STEP_CONST,
  parameter bit                REG_OUT = 1'b1,
  localparam int unsigned      W       = 2 * HALF_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         valid_o,
  output logic [W-1:0] prod_o,
  output logic [W-1:0] step_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] prod_c, scaled_c, step_c;

  gf_tower_mul #(.HALF_W(HALF_W), .POLY(POLY), .EXT(EXT)) u_prod (
    .a_i(a_i), .b_i(b_i), .p_o(prod_c));
  gf_tower_mul #(.HALF_W(HALF_W), .POLY(POLY), .EXT(EXT)) u_step (
    .a_i(a_i), .b_i(GEN), .p_o(scaled_c));

  assign step_c = (a_i == '0) ? ONE : scaled_c;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o <= 1'b0;
        prod_o  <= '0;
        step_o  <= '0;
      end else begin
        valid_o <= valid_i;
        if (valid_i) begin
          prod_o <= prod_c;
          step_o <= step_c;
        end
      end
    end

    p_valid_lat_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> (valid_o && prod_o == $past(prod_c) && step_o == $past(step_c)));
    p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> (!valid_o && $stable(prod_o) && $stable(step_o)));
  end else begin : g_comb
    assign valid_o = valid_i;
    assign prod_o  = prod_c;
    assign step_o  = step_c;
  end

  p_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_i == '0 || b_i == '0) |-> prod_c == '0);
  p_ident_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_i == ONE) |-> prod_c == b_i);
  p_step_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_i == '0) |-> step_c == ONE);
  p_step_scale_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_i != '0 && b_i == GEN) |-> step_c == prod_c);
endmodule

// File: tb/gf4k_tower_mul_tb.sv
`timescale 1ns/1ps
module gf4k_tower_mul_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_in = 1'b0;
  logic [11:0] a_in = '0, b_in = '0;
  logic        valid_out;
  logic [11:0] prod_out, step_out;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gf4k_tower_mul u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_in), .a_i(a_in), .b_i(b_in),
    .valid_o(valid_out), .prod_o(prod_out), .step_o(step_out));

  // R1: bit-serial GF(64) reference, poly 0x43
  function automatic logic [5:0] ref64(input logic [5:0] x, input logic [5:0] y);
    logic [6:0] t = {1'b0, y};
    logic [5:0] r = '0;
    for (int i = 0; i < 6; i++) begin
      if (x[i]) r ^= t[5:0];
      t = {t[5:0], 1'b0};
      if (t[6]) t ^= 7'h43;
    end
    return r;
  endfunction

  // R2 R3 R4
  function automatic logic [11:0] ref4k(input logic [11:0] x, input logic [11:0] y);
    logic [5:0] hi = ref64(x[11:6] ^ x[5:0], y[11:6] ^ y[5:0]) ^ ref64(x[5:0], y[5:0]);
    logic [5:0] lo = ref64(ref64(x[11:6], y[11:6]), 6'h21) ^ ref64(x[5:0], y[5:0]);
    return {hi, lo};
  endfunction

  function automatic logic [11:0] ref_step(input logic [11:0] x);
    return (x == '0) ? 12'h001 : ref4k(x, 12'hE01);
  endfunction

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%03h expected=%03h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [11:0] x, input logic [11:0] y, output logic [11:0] p);
    @(negedge clk);
    valid_in = 1'b1; a_in = x; b_in = y;
    @(posedge clk); #1;
    chk("R10 valid", {11'b0, valid_out}, 12'h001);
    p = prod_out;
    chk("R2/R3/R4 product", prod_out, ref4k(x, y));
    if (x == '0) chk("R8 step zero", step_out, 12'h001);
    else         chk("R9 step scale", step_out, ref_step(x));
  endtask

  initial begin
    logic [11:0] p1, p2, lfsr;
    lfsr = 12'hACE;
    #12;
    chk("R12 reset valid", {11'b0, valid_out}, 12'h000);
    chk("R12 reset prod", prod_out, 12'h000);
    chk("R12 reset step", step_out, 12'h000);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R12 after reset prod", prod_out, 12'h000);

    apply(12'h002, 12'h003, p1);
    chk("R4 2*3", p1, 12'h006);
    apply(12'h040, 12'h040, p1);
    chk("R3 40*40", p1, 12'h061);

    for (int a = 0; a < 4096; a++) begin
      apply(12'(a), 12'h000, p1); chk("R5 zero", p1, 12'h000);
      apply(12'h000, 12'(a), p1); chk("R5 zero left", p1, 12'h000);
      apply(12'(a), 12'h001, p1); chk("R6 identity", p1, 12'(a));
      apply(12'(a), 12'(a), p1);
      apply(12'(a), 12'hE01, p1);
      if (a != 0) chk("R9 step vs product", step_out, p1);
      for (int k = 0; k < 2; k++) begin
        lfsr = {lfsr[10:0], lfsr[11] ^ lfsr[10] ^ lfsr[9] ^ lfsr[3]};
        apply(12'(a), lfsr, p1);
        apply(lfsr, 12'(a), p2);
        chk("R7 commutative", p2, p1);
      end
    end

    // R11: hold while valid low
    apply(12'h123, 12'h456, p1);
    @(negedge clk);
    valid_in = 1'b0; a_in = 12'h7FF; b_in = 12'h3C3;
    @(posedge clk); #1;
    chk("R11 hold valid", {11'b0, valid_out}, 12'h000);
    chk("R11 hold prod", prod_out, p1);
    chk("R11 hold step", step_out, ref_step(12'h123));
    @(posedge clk); #1;
    chk("R11 hold prod 2", prod_out, p1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule